// File: doc/BRIEF.md
# Line-Scan Sensor Acquisition Sequencer

This block produces all the timing needed to pull one banknote image out of a linear-array image sensor through an external pipelined ADC. From the system clock it derives a free-running pixel shift clock and a conversion clock that lags it by one system clock, so that the converter samples only after the sensor output has settled. At the start of every scan line it raises a line-start pulse. An infrared note-presence input is synchronised and gates the start of a frame. Once a frame has begun it always runs to a fixed number of lines of a fixed number of pixels.

Each digitised pixel is taken from the converter at a fixed phase, one conversion-pipeline delay after its shift period, and pushed into a small FIFO. The FIFO is drained by an external DMA channel. A request is raised while the fill level is at or above a threshold, and the channel pops words through a show-ahead read port. If the FIFO fills, a sticky overrun flag stops all further writes until it is cleared, while the line and pixel sequencing continues undisturbed. A one-clock end-of-frame pulse marks the capture slot of the final pixel.

Top module: `linescan_acq`

## Requirements
- R1: `cp_o` is periodic with a period of CP_DIV system clocks (default 4) and is high for the first CP_DIV/2 clocks of each period. It runs whether or not a frame is in progress.
- R2: `adclk_o` is `cp_o` delayed by exactly one system clock: it rises one clock after every rise of `cp_o` and falls one clock after every fall.
- R3: `sp_o` is high for exactly one whole shift period at the start of each line. It is followed by PIX pixel periods (default 800) and then `gap_cfg_i` idle periods before the next line starts. A value of 0 places the next line start immediately after the last pixel period.
- R4: While the sequencer is armed, `note_i` is seen two clocks after it changes. When it is seen high at a period boundary, the next period starts the first line of a frame. A frame contains exactly LINES lines (default 100).
- R5: The sample for pixel period P is the value on `adc_data_i` (SAMPLE_W bits, default 10) at the last clock of period P+ADC_LAT-1 (default ADC_LAT = 3). Samples enter the FIFO in pixel order within a line and in line order within a frame.
- R6: The FIFO holds FIFO_DEPTH words (default 64). `dma_req_o` is high exactly while the fill level is at least DMA_THR (default 16). `rd_valid_o` is high while the FIFO is not empty, and `rd_data_o` then shows the oldest word. `rd_i` pops one word per clock, and `rd_i` while the FIFO is empty has no effect.
- R7: A frame that has started completes all LINES lines even if `note_i` falls during it. After a frame, no new frame starts until `note_i` has been seen low.
- R8: A capture that finds the FIFO full sets `ovr_o`, which stays set until `ovr_clr_i`. While `ovr_o` is set, every capture is discarded. Line and pixel sequencing, and the timing of `sp_o` and `eof_o`, are unaffected. A clear in the same clock as a new overflow leaves the flag set.
- R9: `eof_o` is high for exactly one clock: the clock following the edge that captures the final pixel of the final line of a frame. This holds whether or not that sample was stored.
- R10: During and directly after reset, `cp_o`, `adclk_o`, `sp_o`, `eof_o`, `ovr_o`, `dma_req_o` and `rd_valid_o` are all low, and the sequencer is armed for a new note.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| note_i | input | 1 | Infrared note-presence detector, high while a note is in the path |
| gap_cfg_i | input | GAP_W | Idle shift periods inserted after each line |
| adc_data_i | input | SAMPLE_W | Converter output word |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rd_i | input | 1 | DMA pop strobe |
| cp_o | output | 1 | Sensor pixel shift clock |
| sp_o | output | 1 | Sensor line-start pulse |
| adclk_o | output | 1 | Converter sampling clock |
| rd_data_o | output | SAMPLE_W | Oldest buffered sample (show-ahead) |
| rd_valid_o | output | 1 | Buffer holds at least one sample |
| dma_req_o | output | 1 | DMA service request |
| eof_o | output | 1 | One-clock end-of-frame marker |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
Results fall due at different delays. The two clocks follow the system clock edge by edge. A change on `note_i` can take effect only two clocks later and at the next period boundary. A pixel's word lands in the buffer at the last clock of the period ADC_LAT-1 periods after its shift period. Fill level, request, valid and overrun move one clock after a push or pop, and the frame marker one clock after the final capture. The bench steps a behavioural reference, built from integers and queues, on each rising edge, and compares every output against it on the following falling edge. Each result is therefore checked in exactly the cycle it is due. A pin-level sensor and three-stage converter model supplies pixel words that encode their line and pixel, so any slip in the capture phase shows up as a wrong data word.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   typedef enum logic [2:0] {
      SEQ_ARM   = 3'd0,
      SEQ_SP    = 3'd1,
      SEQ_PIX   = 3'd2,
      SEQ_GAP   = 3'd3,
      SEQ_WEXIT = 3'd4
   } seq_state_e;

endpackage

// File: rtl/lsa_phase_gen.sv
module lsa_phase_gen #(
   parameter int CP_DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic cp_o,
   output logic adclk_o,
   output logic tick_o
);
   localparam int PH_W = $clog2(CP_DIV);
   localparam int HALF = CP_DIV / 2;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(CP_DIV - 1);

   logic [PH_W-1:0] ph_q, ph_n;
   logic cp_q, adclk_q;

   always_comb begin
      if (ph_q == PH_LAST) ph_n = '0;
      else                 ph_n = ph_q + PH_W'(1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q    <= PH_LAST;
         cp_q    <= 1'b0;
         adclk_q <= 1'b0;
      end else begin
         ph_q    <= ph_n;
         cp_q    <= (ph_n < PH_W'(HALF));
         adclk_q <= (ph_n >= PH_W'(1)) && (ph_n <= PH_W'(HALF));
      end
   end

   assign cp_o    = cp_q;
   assign adclk_o = adclk_q;
   assign tick_o  = (ph_q == PH_LAST);

   // R1
   cp_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> $rose(cp_q));

   // R2
   adclk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cp_q) |=> $rose(adclk_q));

   // R2
   adclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cp_q) |=> $fell(adclk_q));

endmodule

// File: rtl/lsa_frame_seq.sv
module lsa_frame_seq
   import lsa_pkg::*;
#(
   parameter int PIX     = 800,
   parameter int LINES   = 100,
   parameter int GAP_W   = 8,
   parameter int ADC_LAT = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             note_i,
   input  logic [GAP_W-1:0] gap_cfg_i,
   output logic             sp_o,
   output logic             cap_o,
   output logic             eof_o
);
   localparam int PIX_W  = $clog2(PIX);
   localparam int LINE_W = $clog2(LINES);
   localparam int TOTAL  = PIX * LINES;
   localparam int CNT_W  = $clog2(TOTAL);
   localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(PIX - 1);
   localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
   localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(TOTAL - 1);

   seq_state_e        st_q, st_n;
   logic [PIX_W-1:0]  pix_q, pix_n;
   logic [LINE_W-1:0] line_q, line_n;
   logic [GAP_W-1:0]  gap_q, gap_n;
   logic              note_s1_q, note_s2_q;
   logic              pix_now, cap_pre;
   logic [CNT_W-1:0]  cnt_q;
   logic              eof_q;

   // two-flop synchroniser for the asynchronous photodetector
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         note_s1_q <= 1'b0;
         note_s2_q <= 1'b0;
      end else begin
         note_s1_q <= note_i;
         note_s2_q <= note_s1_q;
      end
   end

   always_comb begin
      st_n   = st_q;
      pix_n  = pix_q;
      line_n = line_q;
      gap_n  = gap_q;
      if (tick_i) begin
         unique case (st_q)
            SEQ_ARM: begin
               if (note_s2_q) begin
                  st_n   = SEQ_SP;
                  line_n = '0;
               end
            end
            SEQ_SP: begin
               st_n  = SEQ_PIX;
               pix_n = '0;
            end
            SEQ_PIX: begin
               if (pix_q == PIX_LAST) begin
                  pix_n = '0;
                  if (line_q == LINE_LAST) begin
                     st_n = SEQ_WEXIT;
                  end else begin
                     line_n = line_q + LINE_W'(1);
                     gap_n  = '0;
                     st_n   = (gap_cfg_i == '0) ? SEQ_SP : SEQ_GAP;
                  end
               end else begin
                  pix_n = pix_q + PIX_W'(1);
               end
            end
            SEQ_GAP: begin
               if (({1'b0, gap_q} + (GAP_W+1)'(1)) >= {1'b0, gap_cfg_i}) st_n = SEQ_SP;
               else gap_n = gap_q + GAP_W'(1);
            end
            SEQ_WEXIT: begin
               if (!note_s2_q) st_n = SEQ_ARM;
            end
            default: st_n = SEQ_ARM;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= SEQ_ARM;
         pix_q  <= '0;
         line_q <= '0;
         gap_q  <= '0;
      end else begin
         st_q   <= st_n;
         pix_q  <= pix_n;
         line_q <= line_n;
         gap_q  <= gap_n;
      end
   end

   assign pix_now = (st_q == SEQ_PIX);
   assign sp_o    = (st_q == SEQ_SP);

   // capture strobe: a pixel period is taken ADC_LAT-1 periods later
   generate
      if (ADC_LAT == 1) begin : g_lat_direct
         assign cap_pre = pix_now;
      end else if (ADC_LAT == 2) begin : g_lat_one
         logic vp_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     vp_q <= 1'b0;
            else if (tick_i) vp_q <= pix_now;
         end
         assign cap_pre = vp_q;
      end else begin : g_lat_shift
         logic [ADC_LAT-2:0] vp_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     vp_q <= '0;
            else if (tick_i) vp_q <= {vp_q[ADC_LAT-3:0], pix_now};
         end
         assign cap_pre = vp_q[ADC_LAT-2];
      end
   endgenerate

   assign cap_o = tick_i && cap_pre;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         eof_q <= 1'b0;
      end else begin
         eof_q <= cap_o && (cnt_q == CNT_LAST);
         if (cap_o) cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
      end
   end

   assign eof_o = eof_q;

   // R3
   sp_whole_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sp_o) |-> $past(tick_i));

   // R4
   line_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_q <= LINE_LAST);

   // R7
   arm_after_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q != SEQ_ARM && st_q != SEQ_WEXIT) |=> st_q != SEQ_ARM);

   // R9
   eof_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eof_q |=> !eof_q);

endmodule

// File: rtl/lsa_sample_fifo.sv
module lsa_sample_fifo #(
   parameter int DW    = 10,
   parameter int DEPTH = 64,
   parameter int THR   = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          rd_i,
   input  logic          ovr_clr_i,
   output logic [DW-1:0] rd_data_o,
   output logic          rd_valid_o,
   output logic          dma_req_o,
   output logic          ovr_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH + 1);
   localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);
   localparam logic [LW-1:0] LVL_THR  = LW'(THR);

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [LW-1:0] lvl_q;
   logic          ovr_q;
   logic          full, empty, push, pop;

   assign full  = (lvl_q == LVL_FULL);
   assign empty = (lvl_q == '0);
   assign push  = wr_i && !ovr_q && !full;
   assign pop   = rd_i && !empty;

   always_ff @(posedge clk_i) begin
      if (push) mem_q[wp_q] <= wr_data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
         ovr_q <= 1'b0;
      end else begin
         if (push) wp_q <= wp_q + AW'(1);
         if (pop)  rp_q <= rp_q + AW'(1);
         unique case ({push, pop})
            2'b10:   lvl_q <= lvl_q + LW'(1);
            2'b01:   lvl_q <= lvl_q - LW'(1);
            default: lvl_q <= lvl_q;
         endcase
         if (wr_i && full)   ovr_q <= 1'b1;
         else if (ovr_clr_i) ovr_q <= 1'b0;
      end
   end

   assign rd_data_o  = mem_q[rp_q];
   assign rd_valid_o = !empty;
   assign dma_req_o  = (lvl_q >= LVL_THR);
   assign ovr_o      = ovr_q;

   // R6
   level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_q <= LVL_FULL);

   // R6
   req_from_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dma_req_o) |-> $past(push));

   // R8
   ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovr_q && !ovr_clr_i) |=> ovr_q);

   // R8
   ovr_no_growth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_q |=> lvl_q <= $past(lvl_q));

endmodule

// File: rtl/linescan_acq.sv
module linescan_acq #(
   parameter int PIX        = 800,
   parameter int LINES      = 100,
   parameter int SAMPLE_W   = 10,
   parameter int FIFO_DEPTH = 64,
   parameter int DMA_THR    = 16,
   parameter int ADC_LAT    = 3,
   parameter int CP_DIV     = 4,
   parameter int GAP_W      = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                note_i,
   input  logic [GAP_W-1:0]    gap_cfg_i,
   input  logic [SAMPLE_W-1:0] adc_data_i,
   input  logic                ovr_clr_i,
   input  logic                rd_i,
   output logic                cp_o,
   output logic                sp_o,
   output logic                adclk_o,
   output logic [SAMPLE_W-1:0] rd_data_o,
   output logic                rd_valid_o,
   output logic                dma_req_o,
   output logic                eof_o,
   output logic                ovr_o
);
   generate
      if (CP_DIV < 4 || (CP_DIV % 2) != 0) begin : g_bad_div
         $error("CP_DIV must be even and at least 4");
      end
      if (PIX < 2 || LINES < 2) begin : g_bad_frame
         $error("PIX and LINES must be at least 2");
      end
      if (ADC_LAT < 1) begin : g_bad_lat
         $error("ADC_LAT must be at least 1");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two");
      end
      if (DMA_THR < 1 || DMA_THR > FIFO_DEPTH) begin : g_bad_thr
         $error("DMA_THR must lie in 1..FIFO_DEPTH");
      end
   endgenerate

   logic tick, cap;

   lsa_phase_gen #(
      .CP_DIV (CP_DIV)
   ) i_phase (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cp_o    (cp_o),
      .adclk_o (adclk_o),
      .tick_o  (tick)
   );

   lsa_frame_seq #(
      .PIX     (PIX),
      .LINES   (LINES),
      .GAP_W   (GAP_W),
      .ADC_LAT (ADC_LAT)
   ) i_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .note_i    (note_i),
      .gap_cfg_i (gap_cfg_i),
      .sp_o      (sp_o),
      .cap_o     (cap),
      .eof_o     (eof_o)
   );

   lsa_sample_fifo #(
      .DW    (SAMPLE_W),
      .DEPTH (FIFO_DEPTH),
      .THR   (DMA_THR)
   ) i_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (cap),
      .wr_data_i  (adc_data_i),
      .rd_i       (rd_i),
      .ovr_clr_i  (ovr_clr_i),
      .rd_data_o  (rd_data_o),
      .rd_valid_o (rd_valid_o),
      .dma_req_o  (dma_req_o),
      .ovr_o      (ovr_o)
   );

   // R10
   reset_quiet_chk: assert property (@(posedge clk_i)
      !rst_ni |=> !eof_o && !ovr_o && !rd_valid_o);

endmodule

// File: tb/test_linescan_acq.sv
`timescale 1ns/1ps
module test_linescan_acq;
   localparam int PIX   = 16;
   localparam int LINES = 6;
   localparam int SW    = 10;
   localparam int DEPTH = 64;
   localparam int THR   = 16;
   localparam int LAT   = 3;
   localparam int CPD   = 4;
   localparam int GW    = 8;
   localparam int TOTAL = PIX * LINES;
   localparam int WDOG  = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          note = 1'b0;
   logic [GW-1:0] gap_cfg = '0;
   logic [SW-1:0] adc_data = '0;
   logic          ovr_clr = 1'b0;
   logic          rd = 1'b0;
   logic          cp_o, sp_o, adclk_o, rd_valid_o, dma_req_o, eof_o, ovr_o;
   logic [SW-1:0] rd_data_o;

   always #2.5 clk = ~clk;

   linescan_acq #(
      .PIX(PIX), .LINES(LINES), .SAMPLE_W(SW), .FIFO_DEPTH(DEPTH),
      .DMA_THR(THR), .ADC_LAT(LAT), .CP_DIV(CPD), .GAP_W(GW)
   ) i_linescan_acq (
      .clk_i(clk), .rst_ni(rst_n), .note_i(note), .gap_cfg_i(gap_cfg),
      .adc_data_i(adc_data), .ovr_clr_i(ovr_clr), .rd_i(rd),
      .cp_o(cp_o), .sp_o(sp_o), .adclk_o(adclk_o), .rd_data_o(rd_data_o),
      .rd_valid_o(rd_valid_o), .dma_req_o(dma_req_o), .eof_o(eof_o), .ovr_o(ovr_o)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- sensor and converter pin models ----------------
   logic cp_prev = 1'b0, ad_prev = 1'b0;
   int   s_line = 0, s_pix = 0;
   logic [SW-1:0] s_out = '0, a0 = '0, a1 = '0, a2 = '0;

   always @(negedge clk) begin
      if (cp_o && !cp_prev) begin
         if (sp_o) begin
            s_line++;
            s_pix = 0;
         end else begin
            s_out = SW'((s_line - 1) * PIX + s_pix);
            s_pix++;
         end
      end
      if (adclk_o && !ad_prev) begin
         a2 = a1;
         a1 = a0;
         a0 = s_out;
         adc_data = a2;
      end
      cp_prev = cp_o;
      ad_prev = adclk_o;
   end

   // ---------------- DMA read policy ----------------
   int rd_mode = 0;   // 0: on request, 1: never, 2: while valid, 3: always
   always @(negedge clk) begin
      case (rd_mode)
         0: rd = dma_req_o;
         2: rd = rd_valid_o;
         3: rd = 1'b1;
         default: rd = 1'b0;
      endcase
   end

   // ---------------- behavioural reference ----------------
   int m_ph, m_st, m_pix, m_line, m_gapc, m_lg, m_cnt;
   bit m_s1, m_s2, m_eof, m_ovr, m_live;
   int hist[$];
   int q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = CPD - 1; m_st = 0; m_pix = 0; m_line = 0; m_gapc = 0;
         m_lg = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_eof = 0; m_ovr = 0;
         hist.delete(); q.delete();
         for (int i = 0; i < LAT - 1; i++) hist.push_back(-1);
         m_live = 1;
      end else begin
         bit tick, cap, n2, full_pre, ovr_pre;
         int cval;
         tick = (m_ph == CPD - 1);
         cap = 0; cval = 0;
         if (tick) begin
            int cur;
            cur = (m_st == 2) ? (((m_lg - 1) * PIX + m_pix) & 1023) : -1;
            if (LAT == 1) begin
               cap = (cur >= 0); cval = cur;
            end else begin
               cap = (hist[0] >= 0); cval = hist[0];
               void'(hist.pop_front());
               hist.push_back(cur);
            end
         end
         n2 = m_s2; m_s2 = m_s1; m_s1 = note;
         full_pre = (q.size() == DEPTH);
         ovr_pre = m_ovr;
         if (rd && q.size() > 0) void'(q.pop_front());
         if (cap && !ovr_pre && !full_pre) q.push_back(cval);
         m_ovr = (cap && full_pre) ? 1'b1 : (ovr_clr ? 1'b0 : ovr_pre);
         m_eof = cap && (m_cnt == TOTAL - 1);
         if (cap) m_cnt = (m_cnt + 1) % TOTAL;
         if (tick) begin
            case (m_st)
               0: if (n2) begin m_st = 1; m_line = 0; m_lg++; end
               1: begin m_st = 2; m_pix = 0; end
               2: begin
                  if (m_pix == PIX - 1) begin
                     m_pix = 0;
                     if (m_line == LINES - 1) m_st = 4;
                     else begin
                        m_line++;
                        if (gap_cfg == 0) begin m_st = 1; m_lg++; end
                        else begin m_st = 3; m_gapc = 0; end
                     end
                  end else m_pix++;
               end
               3: begin
                  if (m_gapc + 1 >= int'(gap_cfg)) begin m_st = 1; m_lg++; end
                  else m_gapc++;
               end
               default: if (!n2) m_st = 0;
            endcase
            m_ph = 0;
         end else m_ph++;
      end
   end

   // ---------------- per-clock comparison ----------------
   int n_sp = 0, n_eof = 0;
   logic sp_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n && m_live) begin
         chk(cp_o === (m_ph < CPD/2), "R1 cp_o", cp_o, m_ph < CPD/2);
         chk(adclk_o === (m_ph >= 1 && m_ph <= CPD/2), "R2 adclk_o", adclk_o, m_ph >= 1 && m_ph <= CPD/2);
         chk(sp_o === (m_st == 1), "R3 sp_o", sp_o, m_st == 1);
         chk(dma_req_o === (q.size() >= THR), "R6 dma_req_o", dma_req_o, q.size() >= THR);
         chk(rd_valid_o === (q.size() > 0), "R6 rd_valid_o", rd_valid_o, q.size() > 0);
         if (q.size() > 0) chk(int'(rd_data_o) == q[0], "R5 rd_data_o", rd_data_o, q[0]);
         chk(eof_o === m_eof, "R9 eof_o", eof_o, m_eof);
         chk(ovr_o === m_ovr, "R8 ovr_o", ovr_o, m_ovr);
         if (sp_o && !sp_prev) n_sp++;
         if (eof_o) n_eof++;
      end
      sp_prev = sp_o;
   end

   // ---------------- watchdog and summary ----------------
   int cyc = 0;
   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WDOG) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired after %0d cycles", cyc);
         finish_run();
      end
   end

   task automatic wait_eof(input string tag);
      int t;
      t = 0;
      while (!eof_o && t < 5000) begin @(negedge clk); t++; end
      chk(eof_o === 1'b1, tag, eof_o, 1);
      @(negedge clk);
   endtask

   task automatic drain();
      rd_mode = 2;
      while (rd_valid_o) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      // R10 reset state
      repeat (4) @(negedge clk);
      chk(!cp_o && !adclk_o && !sp_o, "R10 clocks idle in reset", {cp_o, adclk_o, sp_o}, 0);
      chk(!eof_o && !ovr_o && !rd_valid_o && !dma_req_o, "R10 flags clear in reset",
          {eof_o, ovr_o, rd_valid_o, dma_req_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!sp_o && !rd_valid_o, "R10 armed and empty after reset", {sp_o, rd_valid_o}, 0);
      repeat (20) @(negedge clk);
      chk(n_sp == 0, "R4 no line without a note", n_sp, 0);

      // frame A: gap 2, DMA on request, note held beyond the frame
      gap_cfg = 8'd2; rd_mode = 0; n_sp = 0; n_eof = 0;
      note = 1'b1;
      wait_eof("R9 frame A end marker");
      chk(n_sp == LINES, "R4 frame A line count", n_sp, LINES);
      repeat (300) @(negedge clk);
      chk(n_sp == LINES, "R7 no rearm while note present", n_sp, LINES);
      chk(n_eof == 1, "R9 single marker frame A", n_eof, 1);
      note = 1'b0;
      drain();

      // frame B: gap 0, short note pulse, reader pops every clock even when empty
      gap_cfg = 8'd0; rd_mode = 3; n_sp = 0; n_eof = 0;
      note = 1'b1;
      repeat (12) @(negedge clk);
      note = 1'b0;
      wait_eof("R7 frame B completes after early exit");
      chk(n_sp == LINES, "R7 frame B line count", n_sp, LINES);
      chk(!rd_valid_o, "R6 empty pop ignored", rd_valid_o, 0);
      repeat (10) @(negedge clk);

      // frame C: gap 5, no reader, FIFO overflows
      gap_cfg = 8'd5; rd_mode = 1; n_sp = 0; n_eof = 0;
      note = 1'b1;
      repeat (30) @(negedge clk);
      note = 1'b0;
      wait_eof("R8 frame C marker despite overrun");
      chk(n_sp == LINES, "R8 line count during overrun", n_sp, LINES);
      chk(ovr_o === 1'b1, "R8 overrun flag set", ovr_o, 1);
      begin
         int pops;
         pops = 0;
         rd_mode = 2;
         while (rd_valid_o) begin @(negedge clk); pops++; end
         chk(pops == DEPTH, "R8 only DEPTH samples kept", pops, DEPTH);
      end
      chk(ovr_o === 1'b1, "R8 flag sticky after drain", ovr_o, 1);
      ovr_clr = 1'b1;
      @(negedge clk);
      ovr_clr = 1'b0;
      chk(ovr_o === 1'b0, "R8 flag cleared", ovr_o, 0);

      // frame D: clean frame after clear
      gap_cfg = 8'd2; rd_mode = 0; n_sp = 0; n_eof = 0;
      note = 1'b1;
      repeat (16) @(negedge clk);
      note = 1'b0;
      wait_eof("R9 frame D end marker");
      chk(ovr_o === 1'b0, "R8 no overrun with reader", ovr_o, 0);
      drain();
      chk(n_eof == 1, "R9 single marker frame D", n_eof, 1);

      finish_run();
   end

endmodule